// File: doc/BRIEF.md
# Local Bus Cycle Termination Controller

This block decides how each processor bus cycle finishes when a nearby local device, a cache for example, may take the cycle over. After a start request it steps through T1 and then a run of T2 states. At the close of the first T2 it takes one look at two active-low inputs: an external ready and a local-claim strobe. From that single sample it does one of three things. It finishes the cycle at once, it hands completion to external logic, or it counts wait states and drives its own ready.

The claim strobe matters only at that one sample point. If external ready is low there, the cycle ends and the claim strobe has no effect. If only the claim is low, the block waits for external ready at the close of each later T2. If neither is low, an internal counter holds the cycle for a configured number of T2 states, never fewer than a fixed minimum. The block then drives ready low during the last of those T2 states. This keeps its own ready clear of any external ready in the first two T2 states. A one-clock done pulse marks the end of every cycle.

Top module: `local_cycle_term`

## Requirements
- R1: While reset is low and in the first cycle after it, the bus state output is idle (code 0), the internal ready drive is high and the done pulse is low.
- R2: A high start input, sampled in idle, gives T1 (code 1) in the next cycle and T2 (code 2) in the cycle after that. T2 repeats until the cycle ends.
- R3: If the external ready input is low at the clock edge that ends the first T2, the cycle ends there after exactly one T2.
- R4: If both the ready input and the claim input are low at that edge, the cycle ends exactly as in R3.
- R5: If only the claim input is low at that edge, the cycle ends at the edge that closes the first later T2 in which external ready is low. The length of this wait has no bound.
- R6: The claim input has no effect at any edge other than the close of the first T2. When it is low in later T2 states, the cycle length and the internal ready drive are unchanged.
- R7: If neither input is low at the first sample, the cycle lasts max(waitCfg, MIN_INT_T2) T2 states, where MIN_INT_T2 defaults to 3. The internal ready drive is low during the last of those T2 states and high in all the others. External ready has no effect in this mode.
- R8: The internal ready drive is never low in the first or second T2 of a cycle, and never low in a cycle that was ended or claimed at the first sample.
- R9: The done output is high for exactly one clock, in the cycle right after the ending edge. In that cycle the bus state is idle.
- R10: The start input is ignored while a cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleStart | input | 1 | Start request; acted on only when idle |
| waitCfg | input | WAIT_W | Number of T2 states for an internally ended cycle |
| lbaN | input | 1 | Active-low local claim strobe |
| readyN | input | 1 | Active-low external ready |
| tState | output | 2 | Bus state: 0 idle, 1 T1, 2 T2 |
| readyDrvN | output | 1 | Active-low internal ready drive |
| cycleDone | output | 1 | One-clock end-of-cycle pulse |

## Verification
The first-sample decision is exercised with each pattern of the two strobes. Ready alone and both together must both give a one-T2 cycle, which separates R3 from R4. The claim alone is paired with external ready arriving at different later T2 states, which shows that the cycle length follows external ready. The case with neither strobe uses wait settings below, at and above the minimum. In those runs a stray external ready and late claim strobes are also applied, so any response to them would change the measured length or the drive pattern. Directed cases cover a start request held high during a cycle and a reset in the middle of a cycle.

// File: rtl/lct_pkg.sv
package lct_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_T1   = 2'd1,
    TS_T2   = 2'd2
  } tstate_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2_FIRST,
    ST_T2_EXT,
    ST_T2_INT
  } ctrl_state_e;

  typedef struct packed {
    logic cntLoad;
    logic cntInc;
    logic intMode;
  } lct_strobe_t;
endpackage

// File: rtl/lct_dpath.sv
module lct_dpath
  import lct_pkg::*;
#(
  parameter int WAIT_W     = 4,
  parameter int MIN_INT_T2 = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  lct_strobe_t       strb,
  input  logic [WAIT_W-1:0] waitCfg,
  output logic              atTarget,
  output logic              readyDrvN
);
  localparam int CNT_W = WAIT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIN_T2  = CNT_W'(MIN_INT_T2);

  logic [CNT_W-1:0] t2Cnt;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cfgWide;

  assign cfgWide = CNT_W'(waitCfg);
  assign target  = (cfgWide < MIN_T2) ? MIN_T2 : cfgWide;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      t2Cnt <= '0;
    end else if (strb.cntLoad) begin
      t2Cnt <= CNT_W'(1);
    end else if (strb.cntInc && t2Cnt != CNT_MAX) begin
      t2Cnt <= t2Cnt + 1'b1;
    end
  end

  assign atTarget  = (t2Cnt == target);
  assign readyDrvN = !(strb.intMode && atTarget);

  // Internal ready never before the minimum T2 index
  assert_drive_late_R8: assert property (@(posedge clk) disable iff (!rstN)
    !readyDrvN |-> (t2Cnt >= MIN_T2));

  // Counter advances by one per internal-mode T2
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.intMode && !atTarget) |=> (t2Cnt == $past(t2Cnt) + 1'b1));
endmodule

// File: rtl/lct_ctrl.sv
module lct_ctrl
  import lct_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cycleStart,
  input  logic        lbaN,
  input  logic        readyN,
  input  logic        atTarget,
  output lct_strobe_t strb,
  output logic [1:0]  tState,
  output logic        cycleDone
);
  ctrl_state_e state, stateNxt;
  logic        endNow;

  always_comb begin
    stateNxt = state;
    endNow   = 1'b0;
    unique case (state)
      ST_IDLE:     if (cycleStart) stateNxt = ST_T1;
      ST_T1:       stateNxt = ST_T2_FIRST;
      ST_T2_FIRST: begin
        if (!readyN) begin
          endNow   = 1'b1;
          stateNxt = ST_IDLE;
        end else if (!lbaN) begin
          stateNxt = ST_T2_EXT;
        end else begin
          stateNxt = ST_T2_INT;
        end
      end
      ST_T2_EXT: if (!readyN) begin
        endNow   = 1'b1;
        stateNxt = ST_IDLE;
      end
      ST_T2_INT: if (atTarget) begin
        endNow   = 1'b1;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cycleDone <= 1'b0;
    end else begin
      state     <= stateNxt;
      cycleDone <= endNow;
    end
  end

  always_comb begin
    strb.cntLoad = (state == ST_T1);
    strb.cntInc  = (state == ST_T2_FIRST) || (state == ST_T2_EXT) || (state == ST_T2_INT);
    strb.intMode = (state == ST_T2_INT);
  end

  always_comb begin
    unique case (state)
      ST_IDLE: tState = TS_IDLE;
      ST_T1:   tState = TS_T1;
      default: tState = TS_T2;
    endcase
  end

  assert_t1_then_t2_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_T1) |=> (state == ST_T2_FIRST));

  assert_first_ready_ends_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_T2_FIRST && !readyN) |=> (cycleDone && state == ST_IDLE));

  assert_ext_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_T2_EXT && readyN) |=> (state == ST_T2_EXT));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_T2_EXT && readyN && cycleStart) |=> (state != ST_T1));
endmodule

// File: rtl/local_cycle_term.sv
module local_cycle_term
  import lct_pkg::*;
#(
  parameter int WAIT_W     = 4,
  parameter int MIN_INT_T2 = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleStart,
  input  logic [WAIT_W-1:0] waitCfg,
  input  logic              lbaN,
  input  logic              readyN,
  output logic [1:0]        tState,
  output logic              readyDrvN,
  output logic              cycleDone
);
  lct_strobe_t strb;
  logic        atTarget;

  lct_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cycleStart(cycleStart),
    .lbaN      (lbaN),
    .readyN    (readyN),
    .atTarget  (atTarget),
    .strb      (strb),
    .tState    (tState),
    .cycleDone (cycleDone)
  );

  lct_dpath #(
    .WAIT_W    (WAIT_W),
    .MIN_INT_T2(MIN_INT_T2)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .waitCfg  (waitCfg),
    .atTarget (atTarget),
    .readyDrvN(readyDrvN)
  );

  // Done pulse only ever seen in idle
  assert_done_in_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> (tState == 2'd0));
endmodule

// File: tb/local_cycle_term_tb_top.sv
module local_cycle_term_tb_top;
  localparam int WAIT_W = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cycleStart = 1'b0;
  logic [WAIT_W-1:0] waitCfg = '0;
  logic              lbaN = 1'b1;
  logic              readyN = 1'b1;
  logic [1:0]        tState;
  logic              readyDrvN;
  logic              cycleDone;

  int  nRun  = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  local_cycle_term #(.WAIT_W(WAIT_W), .MIN_INT_T2(3)) dut_i (
    .clk(clk), .rstN(rstN), .cycleStart(cycleStart), .waitCfg(waitCfg),
    .lbaN(lbaN), .readyN(readyN), .tState(tState),
    .readyDrvN(readyDrvN), .cycleDone(cycleDone)
  );

  typedef struct packed {
    logic [3:0] wcfg;
    logic       lbaFirst;
    logic       rdyFirst;
    logic       junkLba;
    logic [3:0] extAt;
    logic [3:0] expLen;
    logic       expInt;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{4'd5, 1'b0, 1'b1, 1'b0, 4'd0, 4'd1, 1'b0},  // R3 ready alone
    '{4'd5, 1'b1, 1'b1, 1'b0, 4'd0, 4'd1, 1'b0},  // R4 both
    '{4'd5, 1'b1, 1'b0, 1'b0, 4'd4, 4'd4, 1'b0},  // R5 claim, ready at T2 #4
    '{4'd5, 1'b1, 1'b0, 1'b0, 4'd2, 4'd2, 1'b0},  // R5 claim, ready at T2 #2
    '{4'd5, 1'b0, 1'b0, 1'b1, 4'd2, 4'd5, 1'b1},  // R7/R6 stray ready + late claim
    '{4'd0, 1'b0, 1'b0, 1'b0, 4'd0, 4'd3, 1'b1},  // R7 below minimum
    '{4'd3, 1'b0, 1'b0, 1'b0, 4'd0, 4'd3, 1'b1},  // R7 at minimum
    '{4'd9, 1'b0, 1'b0, 1'b1, 4'd0, 4'd9, 1'b1},  // R7/R6 long
    '{4'd2, 1'b1, 1'b0, 1'b1, 4'd7, 4'd7, 1'b0}   // R5 long external wait
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string tagOf(vec_t v);
    if (v.rdyFirst && v.lbaFirst) return "R4";
    if (v.rdyFirst) return "R3";
    if (v.lbaFirst) return "R5";
    if (v.junkLba) return "R6";
    return "R7";
  endfunction

  task automatic runVec(vec_t v);
    string tag;
    tag = tagOf(v);
    @(negedge clk);
    cycleStart = 1'b1; waitCfg = v.wcfg; lbaN = 1'b1; readyN = 1'b1;
    @(negedge clk);
    cycleStart = 1'b0;
    chk(tState == 2'd1, "R2 T1", tState, 1);
    for (int i = 1; i <= int'(v.expLen); i++) begin
      @(negedge clk);
      chk(tState == 2'd2, {tag, " T2 length"}, tState, 2);
      chk(readyDrvN == !(v.expInt && i == int'(v.expLen)),
          (i < 3) ? "R8 drive" : {tag, " drive"}, readyDrvN,
          !(v.expInt && i == int'(v.expLen)));
      readyN = !((i == 1 && v.rdyFirst) || (v.extAt != 0 && i == int'(v.extAt)));
      lbaN   = !((i == 1 && v.lbaFirst) || (i > 1 && v.junkLba));
    end
    @(negedge clk);
    chk(tState == 2'd0, {tag, " end"}, tState, 0);
    chk(cycleDone == 1'b1, "R9 done high", cycleDone, 1);
    lbaN = 1'b1; readyN = 1'b1;
    @(negedge clk);
    chk(cycleDone == 1'b0, "R9 done one clock", cycleDone, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tState == 2'd0, "R1 state", tState, 0);
    chk(readyDrvN == 1'b1, "R1 drive", readyDrvN, 1);
    chk(cycleDone == 1'b0, "R1 done", cycleDone, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(tState == 2'd0, "R1 after release", tState, 0);

    for (int k = 0; k < NVEC; k++) runVec(VECS[k]);

    // R10: start held high while claimed cycle waits
    @(negedge clk);
    cycleStart = 1'b1; waitCfg = 4'd5;
    @(negedge clk);
    chk(tState == 2'd1, "R10 T1", tState, 1);
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      chk(tState == 2'd2, "R10 stays T2", tState, 2);
      lbaN   = !(i == 1);
      readyN = !(i == 3);
      if (i == 3) cycleStart = 1'b0;
    end
    @(negedge clk);
    chk(cycleDone == 1'b1, "R10 done", cycleDone, 1);
    lbaN = 1'b1; readyN = 1'b1;
    @(negedge clk);
    chk(tState == 2'd0, "R10 idle after", tState, 0);

    // R1: reset mid-cycle in internal mode
    cycleStart = 1'b1; waitCfg = 4'd6;
    @(negedge clk);
    cycleStart = 1'b0;
    repeat (4) @(negedge clk);
    chk(tState == 2'd2, "R7 in T2 before reset", tState, 2);
    rstN = 1'b0;
    @(negedge clk);
    chk(tState == 2'd0, "R1 mid reset state", tState, 0);
    chk(readyDrvN == 1'b1, "R1 mid reset drive", readyDrvN, 1);
    chk(cycleDone == 1'b0, "R1 mid reset done", cycleDone, 0);
    rstN = 1'b1;
    @(negedge clk);
    runVec(VECS[6]);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule